// File: doc/BRIEF.md
# Debounced Serial Input Stage

This block is one stage of a cascadable serial input collector. Eight field inputs are registered and then filtered. Each input has its own debounce counter, and a two-bit select chooses the filter time for the whole stage. A serial master selects the stage with an active-low select line. On that falling edge the stage captures a snapshot of the filtered inputs. The snapshot then shifts out MSB-first on the rising edges of the serial clock.

In narrow mode the frame is one data byte. In wide mode a status byte follows the data byte. The status byte holds a 5-bit check code over the data byte and three diagnostic bits. Data on the serial input enters the bottom of the frame. The stage can therefore sit in a chain: the frames of the stages further from the master follow its own frame.

All serial lines are sampled by the system clock through two-flop synchronizers. The serial clock must therefore run well below the system clock.

Top module: `serializer_stage`

## Requirements
- R1: Data byte bit n is field input n. After the select line falls, the frame appears MSB-first on `sdo`, with bit 7 before the first serial clock rise and one bit advancing per rise.
- R2: With `wide_mode`=0 the stage shifts out only its 8-bit data byte before passing on chain data.
- R3: With `wide_mode`=1 the data byte is followed by a status byte, which makes a 16-bit word.
- R4: Status bits [7:3] hold a 5-bit code over the data byte. The generator is x^5+x^4+x^2+1, the data is fed MSB-first and the start value is zero.
- R5: Status bit 1 equals `ot_flag`. Status bit 2 is the inverse of `uv_alarm`. Status bit 0 is the inverse of `uv_warn`.
- R6: `dbsel` values 00, 01, 10 and 11 give a filter of 0, DB_T1 (4), DB_T2 (16) and DB_T3 (64) sample ticks, with one tick every PRESCALE (4) clocks. A filtered bit takes a new value only after the raw input has differed from it for that many consecutive ticks. A shorter pulse is ignored.
- R7: `sdi` is shifted in at the bottom of the frame on each serial clock rise. After 8 rises (narrow mode) or 16 rises (wide mode), `sdo` repeats the `sdi` bits in the order they went in.
- R8: The frame is captured when the select line falls. Input changes while the select line is low do not alter the frame.
- R9: `fault` is high exactly when `ot_flag` or `uv_alarm` was high on the previous clock.
- R10: `sdo` is 0 while the select line is high.
- R11: After reset, `sdo` and `fault` are 0 and the filtered inputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_in | input | 8 | Raw field inputs |
| wide_mode | input | 1 | 1 = data plus status, 0 = data only |
| dbsel | input | 2 | Debounce time select |
| ot_flag | input | 1 | Overtemperature condition |
| uv_alarm | input | 1 | Undervoltage alarm condition |
| uv_warn | input | 1 | Undervoltage warning condition |
| cs_n | input | 1 | Active-low stage select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data from the downstream stage |
| sdo | output | 1 | Serial data toward the master |
| fault | output | 1 | Active-high fault indicator |

## Verification
The bench sends pulses just shorter than each filter window and inputs held just longer than it. A filter that counted wrongly, or that did not restart its count when a glitch ended, would let the pulse through or would never settle. Random frames check the check-code bits and the inverted polarity of the undervoltage bits. A wrong generator, bit order or inversion would corrupt the status byte. Chain data follows exactly 8 or 16 bits. Inserting it at the wrong position, or shifting too far in narrow mode, would misplace the downstream byte. Changing the inputs after the select line falls catches a design that keeps reloading the frame while it shifts.

// File: rtl/serializer_stage.sv
module serializer_stage #(
  parameter int PRESCALE = 4,
  parameter int DB_T1    = 4,
  parameter int DB_T2    = 16,
  parameter int DB_T3    = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] field_in,
  input  logic       wide_mode,
  input  logic [1:0] dbsel,
  input  logic       ot_flag,
  input  logic       uv_alarm,
  input  logic       uv_warn,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  output logic       fault
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int CW = $clog2(DB_T3 + 1);

  logic [PW-1:0] pre_q;
  logic          tick;
  logic [7:0]    raw_q, filt_q;
  logic [CW-1:0] thr;
  logic [CW-1:0] cnt_q [8];

  assign tick = (pre_q == PW'(PRESCALE - 1));

  always_ff @(posedge clk)
    if (!rst_n)    pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;

  always_ff @(posedge clk)
    if (!rst_n) raw_q <= '0;
    else        raw_q <= field_in;

  always_comb
    case (dbsel)
      2'b01:   thr = CW'(DB_T1);
      2'b10:   thr = CW'(DB_T2);
      2'b11:   thr = CW'(DB_T3);
      default: thr = '0;
    endcase

  for (genvar g = 0; g < 8; g++) begin : g_flt
    always_ff @(posedge clk)
      if (!rst_n) begin
        filt_q[g] <= 1'b0;
        cnt_q[g]  <= '0;
      end else if (dbsel == 2'b00) begin
        filt_q[g] <= raw_q[g];
        cnt_q[g]  <= '0;
      end else if (raw_q[g] == filt_q[g]) begin
        cnt_q[g]  <= '0;
      end else if (tick) begin
        if (cnt_q[g] + 1'b1 >= thr) begin
          filt_q[g] <= raw_q[g];
          cnt_q[g]  <= '0;
        end else begin
          cnt_q[g]  <= cnt_q[g] + 1'b1;
        end
      end
  end

  function automatic logic [4:0] chk5(input logic [7:0] d);
    logic [4:0] c;
    logic       fb;
    c = '0;
    for (int i = 7; i >= 0; i--) begin
      fb = c[4] ^ d[i];
      c  = {c[3:0], 1'b0} ^ (fb ? 5'h15 : 5'h00);
    end
    return c;
  endfunction

  logic [7:0] status;
  assign status = {chk5(filt_q), ~uv_alarm, ot_flag, ~uv_warn};

  logic cs_s1, cs_s2, cs_p;
  logic ck_s1, ck_s2, ck_p;
  logic di_s1, di_s2;

  always_ff @(posedge clk)
    if (!rst_n) begin
      {cs_s1, cs_s2, cs_p} <= 3'b111;
      {ck_s1, ck_s2, ck_p} <= 3'b000;
      {di_s1, di_s2}       <= 2'b00;
    end else begin
      {cs_s1, cs_s2, cs_p} <= {cs_n, cs_s1, cs_s2};
      {ck_s1, ck_s2, ck_p} <= {sclk, ck_s1, ck_s2};
      {di_s1, di_s2}       <= {sdi, di_s1};
    end

  logic cs_fall, ck_rise;
  assign cs_fall = cs_p & ~cs_s2;
  assign ck_rise = ~ck_p & ck_s2 & ~cs_s2;

  logic [15:0] shreg;
  logic        wide_q;

  always_ff @(posedge clk)
    if (!rst_n) begin
      shreg  <= '0;
      wide_q <= 1'b0;
    end else if (cs_fall) begin
      shreg  <= {filt_q, wide_mode ? status : 8'h00};
      wide_q <= wide_mode;
    end else if (ck_rise) begin
      if (wide_q) shreg       <= {shreg[14:0], di_s2};
      else        shreg[15:8] <= {shreg[14:8], di_s2};
    end

  assign sdo = ~cs_s2 & shreg[15];

  always_ff @(posedge clk)
    if (!rst_n) fault <= 1'b0;
    else        fault <= ot_flag | uv_alarm;

endmodule

module serializer_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sdo,
  input logic       fault,
  input logic       ot_flag,
  input logic       uv_alarm,
  input logic       tick,
  input logic [1:0] dbsel,
  input logic [7:0] raw_q,
  input logic [7:0] filt_q
);
  // R9
  fault_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault == $past(ot_flag | uv_alarm));

  // R10
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !sdo);

  // R6
  filt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && dbsel != 2'b00) |=> $stable(filt_q));

  // R6
  filt_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_q ^ $past(filt_q)) & (filt_q ^ $past(raw_q))) == 8'h00);
endmodule

bind serializer_stage serializer_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .fault(fault),
  .ot_flag(ot_flag), .uv_alarm(uv_alarm), .tick(tick), .dbsel(dbsel),
  .raw_q(raw_q), .filt_q(filt_q)
);

// File: tb/test_serializer_stage.sv
module test_serializer_stage;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] field_in = 8'hFF;
  logic       wide_mode = 1'b0;
  logic [1:0] dbsel = 2'b11;
  logic       ot_flag = 1'b0, uv_alarm = 1'b0, uv_warn = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic       sdo, fault;
  int         errors = 0, checks = 0;

  always #4 clk = ~clk;

  serializer_stage i_serializer_stage (
    .clk(clk), .rst_n(rst_n), .field_in(field_in), .wide_mode(wide_mode),
    .dbsel(dbsel), .ot_flag(ot_flag), .uv_alarm(uv_alarm), .uv_warn(uv_warn),
    .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo), .fault(fault));

  function automatic logic [4:0] ref_code(input logic [7:0] d);
    logic [4:0] c = '0;
    for (int i = 7; i >= 0; i--)
      c = {c[3:0], 1'b0} ^ ((c[4] ^ d[i]) ? 5'h15 : 5'h00);
    return c;
  endfunction

  function automatic logic [7:0] ref_status(input logic [7:0] d, input logic ot,
                                            input logic uva, input logic uvw);
    return {ref_code(d), ~uva, ot, ~uvw};
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic frame(input int nbits, input logic [7:0] chain, input bit chg,
                       input logic [7:0] newval, output logic [31:0] got);
    got = '0;
    cs_n = 1'b0;
    wclk(8);
    if (chg) begin
      field_in = newval;
      wclk(8);
    end
    for (int k = 0; k < nbits; k++) begin
      got = {got[30:0], sdo};
      sdi = (k < 8) ? chain[7-k] : 1'b0;
      wclk(2);
      sclk = 1'b1;
      wclk(8);
      sclk = 1'b0;
      wclk(8);
    end
    cs_n = 1'b1;
    sdi = 1'b0;
    wclk(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic [7:0]  d, ch;
    int unsigned seed;
    seed = $urandom(17);
    wclk(5);
    rst_n = 1'b1;
    wclk(2);
    // R11 reset state
    check("R11 sdo", {31'd0, sdo}, 32'd0);
    check("R11 fault", {31'd0, fault}, 32'd0);
    frame(8, 8'h00, 1'b0, 8'h00, got);
    check("R11 filtered zero", got, 32'd0);

    // R1 R2 R3 R4 R5 R7 R9 random frames
    dbsel = 2'b00;
    for (int t = 0; t < 20; t++) begin
      d = 8'($urandom); ch = 8'($urandom);
      if (t == 0) begin d = 8'h00; ch = 8'hFF; end
      if (t == 1) begin d = 8'hFF; ch = 8'h00; end
      if (t == 2) begin d = 8'h01; ch = 8'h80; end
      field_in = d;
      wide_mode = (t == 0) ? 1'b1 : 1'($urandom);
      {ot_flag, uv_alarm, uv_warn} = 3'($urandom);
      wclk(3);
      check("R9 fault", {31'd0, fault}, {31'd0, ot_flag | uv_alarm});
      if (wide_mode) begin
        frame(24, ch, 1'b0, 8'h00, got);
        check("R3 R4 R5 R7 wide frame", got,
              {8'h00, d, ref_status(d, ot_flag, uv_alarm, uv_warn), ch});
      end else begin
        frame(16, ch, 1'b0, 8'h00, got);
        check("R1 R2 R7 narrow frame", got, {16'h0000, d, ch});
      end
    end
    {ot_flag, uv_alarm, uv_warn} = 3'b000;

    // R8 snapshot at select fall
    field_in = 8'hA5; wide_mode = 1'b1;
    wclk(4);
    frame(16, 8'h00, 1'b1, 8'h5A, got);
    check("R8 snapshot", got, {16'h0000, 8'hA5, ref_status(8'hA5, 1'b0, 1'b0, 1'b0)});
    wide_mode = 1'b0;
    field_in = 8'h3C;
    wclk(4);

    // R6 filter 4 ticks
    dbsel = 2'b01;
    field_in = 8'hC3; wclk(8); field_in = 8'h3C; wclk(40);
    frame(8, 8'h00, 1'b0, 8'h00, got);
    check("R6 short pulse db01", got, 32'h3C);
    field_in = 8'hC3; wclk(30);
    frame(8, 8'h00, 1'b0, 8'h00, got);
    check("R6 held input db01", got, 32'hC3);

    // R6 filter 16 ticks
    dbsel = 2'b10;
    field_in = 8'h0F; wclk(40); field_in = 8'hC3; wclk(10);
    frame(8, 8'h00, 1'b0, 8'h00, got);
    check("R6 short pulse db10", got, 32'hC3);
    field_in = 8'h0F; wclk(90);
    frame(8, 8'h00, 1'b0, 8'h00, got);
    check("R6 held input db10", got, 32'h0F);

    // R6 filter 64 ticks
    dbsel = 2'b11;
    field_in = 8'hF0; wclk(100);
    frame(8, 8'h00, 1'b0, 8'h00, got);
    check("R6 partial hold db11", got, 32'h0F);
    field_in = 8'hF0; wclk(300);
    frame(8, 8'h00, 1'b0, 8'h00, got);
    check("R6 held input db11", got, 32'hF0);

    // R10 idle line
    check("R10 sdo idle", {31'd0, sdo}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule